// File: doc/BRIEF.md
# Fabric Configuration Mode Sequencer

This block walks a programmable-logic fabric through its configuration lifecycle for a host. The host writes a control register and reads a status register over a simple word-addressed register port. Individual control bits drive the transitions between five modes: power-off, reset, config, init and user. The block also drives the fabric-side handshake lines: a configuration pull line, an active-low chip enable and a configuration clock. It samples the fabric's status and done flags.

While the data-path enable bit is set, configuration words offered on a separate 32-bit port are passed to the fabric one cycle later. Once the fabric reports done and the host has closed the data path, the block issues four configuration clock pulses, paced by a programmable clock-to-data ratio, and then enters user mode. Clearing the enable bit releases every handshake output and freezes the mode and the pulse pacing until the bit is set again.

Top module: `cfgseq_top`

## Requirements
- R1: During reset and right after it: mode is power-off (code 0), the control register reads 0, `fab_pull_o`=0, `fab_ce_no`=1, `fab_dclk_o`=0 and `fab_word_vld_o`=0.
- R2: Reading address 0x0 returns the mode in bits 2:0 (power-off=0, reset=1, config=2, init=3, user=4) and the 5-bit mode-select value in bits 7:3. That value is captured on the first clock after reset is released, and later changes of `msel_i` are ignored. All other bits read 0.
- R3: Address 0x4 holds the control register: enable bit 0, active-low chip enable bit 1, pull bit 2, ratio bits 7:6, data-path enable bit 8, width bit 9 (0 = 16-bit, 1 = 32-bit). It reads back as written, with all other bits 0. Writes to other addresses leave it unchanged.
- R4: While enabled, a set pull bit moves power-off, config, init or user to reset. Mode changes take effect on the clock after the control write. Power-off is left only this way.
- R5: While enabled, reset moves to config on the first clock on which the pull bit is clear.
- R6: In config, a low `fab_status_i` moves the mode to reset on the next clock.
- R7: A word offered with `cfg_word_we_i` appears on `fab_word_o` with `fab_word_vld_o` high one cycle later, as a full 32-bit word, only if enable and data-path enable are both set. Otherwise `fab_word_vld_o` stays low.
- R8: Config moves to init on the first clock where `fab_done_i` is high and the data-path enable bit is clear. While the data path is enabled the mode stays in config.
- R9: In init, `fab_dclk_o` pulses high for one cycle every N cycles, where N is 1, 2, 4 or 8 for ratio codes 0 to 3. The first pulse comes N cycles after init is entered. The clock that consumes the fourth pulse moves the mode to user. Only init reaches user, and pulses occur only in init.
- R10: With the enable bit clear, `fab_pull_o`=0, `fab_ce_no`=1 and `fab_dclk_o`=0, no words are accepted, and the mode and the pulse pacing hold.
- R11: With the enable bit set, `fab_ce_no` follows control bit 1 and `fab_pull_o` follows control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| msel_i | input | 5 | Mode-select pins |
| cfg_word_we_i | input | 1 | Configuration word offered |
| cfg_word_i | input | 32 | Configuration word |
| fab_word_vld_o | output | 1 | Word valid towards fabric |
| fab_word_o | output | 32 | Word towards fabric |
| fab_pull_o | output | 1 | Configuration pull line |
| fab_ce_no | output | 1 | Active-low chip enable |
| fab_dclk_o | output | 1 | Configuration clock pulse |
| fab_status_i | input | 1 | Fabric status flag |
| fab_done_i | input | 1 | Fabric configuration done flag |

## Verification
A control write lands in the register on the clock that samples it, so its output effects (pull, chip enable, readback) are visible in the next low phase. The mode follows one clock later. An accepted word appears one clock after it is offered. In init with ratio N, pulse k shows in the cycle before clock k·N after init was entered, and user follows that clock. A behavioural model in the bench applies these same latencies at every rising edge, and every output is compared with it at each falling edge. Point checks sample the mode at hand-counted cycles on each boundary.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'd0,
    M_RST  = 3'd1,
    M_CFG  = 3'd2,
    M_INIT = 3'd3,
    M_USER = 3'd4
  } mode_e;

  typedef struct packed {
    logic       wid32;
    logic       dp_en;
    logic [1:0] ratio;
    logic       pull;
    logic       nce;
    logic       en;
  } ctrl_t;

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    return {22'd0, c.wid32, c.dp_en, c.ratio, 3'd0, c.pull, c.nce, c.en};
  endfunction

  function automatic ctrl_t word_to_ctrl(logic [31:0] w);
    ctrl_t c;
    c.wid32 = w[9];
    c.dp_en = w[8];
    c.ratio = w[7:6];
    c.pull  = w[2];
    c.nce   = w[1];
    c.en    = w[0];
    return c;
  endfunction
endpackage

// File: rtl/cfgseq_regs.sv
module cfgseq_regs
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int MSEL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  mode_e             mode_i,
  output ctrl_t             ctrl_o,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam int PAD_W = 32 - 3 - MSEL_W;

  ctrl_t             ctrl_q;
  logic [MSEL_W-1:0] msel_q;
  logic              cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && addr_i == A_CTRL) begin
      ctrl_q <= word_to_ctrl(wdata_i);
    end
  end

  // mode-select pins latched once, first clock out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msel_q <= '0;
      cap_q  <= 1'b0;
    end else if (!cap_q) begin
      msel_q <= msel_i;
      cap_q  <= 1'b1;
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = {{PAD_W{1'b0}}, msel_q, mode_i};
      A_CTRL:  rdata_o = ctrl_to_word(ctrl_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i || addr_i != A_CTRL) |=> $stable(ctrl_q)); // R3
  AST_MSEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> $stable(msel_q)); // R2
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int PULSES  = 4,
  parameter int RATIO_W = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  fab_status_i,
  input  logic  fab_done_i,
  output mode_e mode_o,
  output logic  dclk_o
);
  localparam int CNT_W = $clog2(PULSES + 1);
  localparam int DIV_W = (2 ** RATIO_W) - 1;

  mode_e            mode_q, mode_d;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W:0]   span;
  logic             pulse, last;

  assign span  = ((DIV_W + 1)'(1) << ctrl_i.ratio) - (DIV_W + 1)'(1);
  assign pulse = ctrl_i.en && mode_q == M_INIT && div_q == span[DIV_W-1:0];
  assign last  = cnt_q == CNT_W'(PULSES - 1);

  always_comb begin
    mode_d = mode_q;
    if (ctrl_i.en) begin
      case (mode_q)
        M_OFF:  if (ctrl_i.pull) mode_d = M_RST;
        M_RST:  if (!ctrl_i.pull) mode_d = M_CFG;
        M_CFG: begin
          if (ctrl_i.pull || !fab_status_i) mode_d = M_RST;
          else if (fab_done_i && !ctrl_i.dp_en) mode_d = M_INIT;
        end
        M_INIT: begin
          if (ctrl_i.pull) mode_d = M_RST;
          else if (pulse && last) mode_d = M_USER;
        end
        M_USER: if (ctrl_i.pull) mode_d = M_RST;
        default: mode_d = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_OFF;
    else         mode_q <= mode_d;
  end

  // pacing of the trailing configuration clocks, frozen while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (ctrl_i.en) begin
      if (mode_q != M_INIT) begin
        div_q <= '0;
        cnt_q <= '0;
      end else if (pulse) begin
        div_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mode_o = mode_q;
  assign dclk_o = pulse;

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q inside {M_OFF, M_RST, M_CFG, M_INIT, M_USER}); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |=> $stable(mode_q)); // R10
  AST_OFF_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == M_OFF |=> mode_q inside {M_OFF, M_RST}); // R4
  AST_USER_VIA_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != M_INIT && mode_q != M_USER) |=> mode_q != M_USER); // R9
  AST_PULSE_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> mode_q == M_INIT); // R9
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int MSEL_W  = 5,
  parameter int DATA_W  = 32,
  parameter int PULSES  = 4,
  parameter int RATIO_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              cfg_word_we_i,
  input  logic [DATA_W-1:0] cfg_word_i,
  output logic              fab_word_vld_o,
  output logic [DATA_W-1:0] fab_word_o,
  output logic              fab_pull_o,
  output logic              fab_ce_no,
  output logic              fab_dclk_o,
  input  logic              fab_status_i,
  input  logic              fab_done_i
);
  ctrl_t             ctrl;
  mode_e             mode;
  logic              take;
  logic              vld_q;
  logic [DATA_W-1:0] word_q;

  cfgseq_regs #(.ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .msel_i  (msel_i),
    .mode_i  (mode),
    .ctrl_o  (ctrl),
    .rdata_o (reg_rdata_o)
  );

  cfgseq_fsm #(.PULSES(PULSES), .RATIO_W(RATIO_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .fab_status_i (fab_status_i),
    .fab_done_i   (fab_done_i),
    .mode_o       (mode),
    .dclk_o       (fab_dclk_o)
  );

  assign take = cfg_word_we_i && ctrl.en && ctrl.dp_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= take;
      if (take) word_q <= cfg_word_i;
    end
  end

  assign fab_word_vld_o = vld_q;
  assign fab_word_o     = word_q;
  assign fab_pull_o     = ctrl.en && ctrl.pull;
  assign fab_ce_no      = ctrl.en ? ctrl.nce : 1'b1;

  AST_WORD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_word_we_i && !(ctrl.en && ctrl.dp_en)) |=> !fab_word_vld_o); // R7
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_word_we_i |=> $stable(fab_word_o)); // R7
endmodule

// File: tb/cfgseq_top_test.sv
`timescale 1ns/1ps
module cfgseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  msel = 5'h0A;
  logic        word_we = 1'b0;
  logic [31:0] word_in = '0;
  logic        word_vld;
  logic [31:0] word_out;
  logic        pull, ce_n, dclk;
  logic        fstat = 1'b0;
  logic        fdone = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfgseq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .msel_i(msel),
    .cfg_word_we_i(word_we), .cfg_word_i(word_in), .fab_word_vld_o(word_vld),
    .fab_word_o(word_out), .fab_pull_o(pull), .fab_ce_no(ce_n),
    .fab_dclk_o(dclk), .fab_status_i(fstat), .fab_done_i(fdone)
  );

  // behavioural reference
  int          m_mode = 0;
  int          m_div = 0;
  int          m_cnt = 0;
  logic [31:0] m_ctrl = '0;
  logic [4:0]  m_msel = '0;
  bit          m_cap = 0;
  bit          m_vld = 0;
  logic [31:0] m_word = '0;

  function automatic bit m_pulse();
    int n;
    n = 1 << m_ctrl[7:6];
    return m_ctrl[0] && m_mode == 3 && m_div == n - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_div = 0; m_cnt = 0; m_ctrl = '0; m_msel = '0;
      m_cap = 0; m_vld = 0; m_word = '0;
    end else begin
      bit en, pl, dp, pz;
      int nm;
      en = m_ctrl[0]; pl = m_ctrl[2]; dp = m_ctrl[8]; pz = m_pulse();
      nm = m_mode;
      if (en) begin
        if (m_mode == 0 && pl) nm = 1;
        else if (m_mode == 1 && !pl) nm = 2;
        else if (m_mode == 2) begin
          if (pl || !fstat) nm = 1;
          else if (fdone && !dp) nm = 3;
        end else if (m_mode == 3) begin
          if (pl) nm = 1;
          else if (pz && m_cnt == 3) nm = 4;
        end else if (m_mode == 4 && pl) nm = 1;
        if (m_mode != 3) begin m_div = 0; m_cnt = 0; end
        else if (pz) begin m_div = 0; m_cnt = m_cnt + 1; end
        else m_div = (m_div + 1) % 8;
      end
      m_mode = nm;
      m_vld = word_we && en && dp;
      if (m_vld) m_word = word_in;
      if (reg_wr && reg_addr == 4'h4) m_ctrl = reg_wdata & 32'h0000_03C7;
      if (!m_cap) begin m_msel = msel; m_cap = 1; end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [31:0] er;
    er = (reg_addr == 4'h0) ? {24'd0, m_msel, m_mode[2:0]} :
         (reg_addr == 4'h4) ? m_ctrl : 32'd0;
    chk(!rst_n ? "R1" : (reg_addr == 4'h4 ? "R3" : "R2"), "rdata", reg_rdata, er);
    chk(!rst_n ? "R1" : "R11/R10", "pull", 32'(pull), 32'(m_ctrl[0] && m_ctrl[2]));
    chk(!rst_n ? "R1" : "R11/R10", "ce_n", 32'(ce_n), 32'(m_ctrl[0] ? m_ctrl[1] : 1'b1));
    chk(!rst_n ? "R1" : "R9", "dclk", 32'(dclk), 32'(m_pulse()));
    chk(!rst_n ? "R1" : "R7", "word_vld", 32'(word_vld), 32'(m_vld));
    if (m_vld) chk("R7", "word", word_out, m_word);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr_ctrl(logic [31:0] v);
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = v;
    tick();
    reg_wr = 1'b0; reg_addr = 4'h0;
  endtask

  task automatic want_mode(int code, string tag);
    reg_addr = 4'h0;
    #1;
    chk(tag, "mode", 32'(reg_rdata[2:0]), 32'(code));
  endtask

  initial begin
    tick(3);
    chk("R1", "mode", 32'(reg_rdata[2:0]), 32'd0);
    chk("R1", "ce_n", 32'(ce_n), 32'd1);
    chk("R1", "pull", 32'(pull), 32'd0);
    rst_n = 1'b1;
    tick(2);
    chk("R2", "msel", 32'(reg_rdata[7:3]), 32'h0A);
    msel = 5'h15;
    tick();
    chk("R2", "msel kept", 32'(reg_rdata[7:3]), 32'h0A);
    wr_ctrl(32'h1);
    tick(2);
    want_mode(0, "R4");
    wr_ctrl(32'h5);
    tick();
    want_mode(1, "R4");
    chk("R11", "pull", 32'(pull), 32'd1);
    reg_addr = 4'h4; #1;
    chk("R3", "ctrl", reg_rdata, 32'h5);
    fstat = 1'b1;
    wr_ctrl(32'h1);
    tick();
    want_mode(2, "R5");
    word_we = 1'b1; word_in = 32'h1234_5678;
    tick();
    word_we = 1'b0;
    chk("R7", "no dp", 32'(word_vld), 32'd0);
    wr_ctrl(32'h141);
    word_we = 1'b1; word_in = 32'hDEAD_BEEF;
    tick();
    word_we = 1'b0;
    chk("R7", "vld", 32'(word_vld), 32'd1);
    chk("R7", "word", word_out, 32'hDEAD_BEEF);
    tick();
    fstat = 1'b0;
    tick();
    want_mode(1, "R6");
    fstat = 1'b1;
    tick();
    want_mode(2, "R5");
    fdone = 1'b1;
    tick(3);
    want_mode(2, "R8");
    wr_ctrl(32'h041);
    tick();
    want_mode(3, "R8");
    tick(2);
    wr_ctrl(32'h040);
    word_we = 1'b1; word_in = 32'hCAFE_0001;
    tick(5);
    word_we = 1'b0;
    want_mode(3, "R10");
    chk("R10", "ce_n", 32'(ce_n), 32'd1);
    chk("R10", "dclk", 32'(dclk), 32'd0);
    chk("R10", "vld", 32'(word_vld), 32'd0);
    wr_ctrl(32'h041);
    tick(4);
    want_mode(3, "R9");
    tick();
    want_mode(4, "R9");
    wr_ctrl(32'h045);
    chk("R11", "ce_n", 32'(ce_n), 32'd0);
    tick();
    want_mode(1, "R4");
    wr_ctrl(32'h047);
    chk("R11", "ce_n", 32'(ce_n), 32'd1);
    wr_ctrl(32'h0C1);
    tick(33);
    want_mode(3, "R9");
    tick();
    want_mode(4, "R9");
    wr_ctrl(32'hFFFF_FFFF);
    reg_addr = 4'h4; #1;
    chk("R3", "ctrl all", reg_rdata, 32'h3C7);
    reg_addr = 4'h8; #1;
    chk("R3", "unmapped", reg_rdata, 32'h0);
    reg_wr = 1'b1; reg_wdata = 32'h0; tick(); reg_wr = 1'b0;
    reg_addr = 4'h4; #1;
    chk("R3", "ctrl kept", reg_rdata, 32'h3C7);
    tick();
    want_mode(1, "R4");
    wr_ctrl(32'h1);
    tick(5);
    want_mode(3, "R9");
    tick();
    want_mode(4, "R9");
    tick(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule